// File: doc/BRIEF.md
# I2C Serial EEPROM Read Slave

This block is the bus-facing half of a serial EEPROM that answers read traffic on a two-wire I2C bus. It watches SCL and SDA, recognises START and STOP, and checks the device address byte against a fixed 4-bit device code and three strap pins. It keeps a 14-bit word-address counter. A write-type transfer loads that counter from two address bytes and stores no data.

A read-type transfer streams bytes from a synchronous byte-read memory port, most significant bit first. The master may take one byte and refuse the next (current-address or random read), or it may keep acknowledging to stream through the array (sequential read). The counter wraps from the top of the array to zero. After every byte sent, the counter points one past that byte, so a later current-address read resumes where the last read stopped.

SDA is modelled as an open-drain line: the block has an input for the line level and an output that pulls the line low. Both bus inputs pass through two synchroniser flip-flops. Edges are found on the synchronised copies.

Top module: `i2c_eeprom_rd_slave`

## Requirements
- R1: After reset the SDA pull-down is off and the word-address counter (visible on the memory address port) is 0.
- R2: A device byte whose upper seven bits equal the device code 1010 followed by strap[2:0] is acknowledged: SDA is held low for the whole ninth SCL high phase.
- R3: A device byte with any other upper seven bits is not acknowledged. Every later byte is then ignored until the next START: it gets no acknowledge and the counter keeps its value.
- R4: After a write-type device byte (bit 0 = 0), two address bytes follow, high byte first. Each is acknowledged. The counter is loaded with {high[5:0], low}, so the top two bits of the high byte have no effect.
- R5: A repeated START followed by a read-type device byte (bit 0 = 1) returns the byte stored at the newly loaded address, MSB first, one bit per SCL clock.
- R6: A read with no preceding address load returns the byte at the current counter value. Every byte sent advances the counter by one.
- R7: When the master answers a data byte with 0 (ACK), the next byte sent is the one at the following address.
- R8: When a sequential read passes address 0x3FFF, it continues at address 0x0000.
- R9: When the master answers a data byte with 1 (NACK), the block releases SDA and goes idle. Until the next START it does not drive SDA, including the acknowledge slot of any further byte. A START or STOP always releases SDA.
- R10: The block changes SDA only while SCL is low. The level it drives is stable throughout every SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap | input | 3 | Hardware address strap bits, compared with device byte bits 3..1 |
| scl_in | input | 1 | I2C clock line level |
| sda_in | input | 1 | I2C data line level |
| sda_low | output | 1 | When 1, pull the SDA line low |
| mem_addr | output | 14 | Word address presented to the memory array |
| mem_data | input | 8 | Byte returned by the memory array one clock after mem_addr |

## Verification
Every bus result trails the SCL edge that causes it by three system clocks: two synchroniser stages and one output register. An acknowledge or data bit appears that long after the SCL falling edge that opens its slot. The counter moves that long after the eighth falling edge of a data byte. The memory port adds one more clock before the next byte can be loaded. The bench holds each SCL phase for many more clocks than this and samples SDA just after SCL rises and again just before it falls, so every value is read after it is due and while it must be stable.

// File: rtl/i2c_eeprom_rd_slave.sv
module i2c_eeprom_rd_slave #(
  parameter int          AW     = 14,
  parameter logic [3:0]  DEV_ID = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    strap,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_low,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_data
);
  localparam int HI_W = AW - 8;

  typedef enum logic [3:0] {
    S_IDLE = 4'd0, S_DEV = 4'd1, S_DACK = 4'd2, S_AH = 4'd3, S_AHACK = 4'd4,
    S_AL = 4'd5, S_ALACK = 4'd6, S_TX = 4'd7, S_TACK = 4'd8
  } st_t;

  logic [1:0]      scl_sy, sda_sy;
  logic            scl_q, sda_q;
  logic            scl_s, sda_s;
  logic            start_c, stop_c, scl_rise, scl_fall;
  st_t             st;
  logic [3:0]      bcnt;
  logic [7:0]      sreg, txsr;
  logic [HI_W-1:0] hi;
  logic [AW-1:0]   waddr;
  logic            rw, mack;

  assign scl_s    = scl_sy[1];
  assign sda_s    = sda_sy[1];
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign mem_addr = waddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      bcnt    <= '0;
      sreg    <= '0;
      txsr    <= '0;
      hi      <= '0;
      waddr   <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      sda_low <= 1'b0;
    end else if (start_c) begin
      st      <= S_DEV;
      bcnt    <= '0;
      sda_low <= 1'b0;
    end else if (stop_c) begin
      st      <= S_IDLE;
      sda_low <= 1'b0;
    end else begin
      case (st)
        S_DEV, S_AH, S_AL: begin
          if (scl_rise && bcnt != 4'd8) begin
            sreg <= {sreg[6:0], sda_s};
            bcnt <= bcnt + 4'd1;
          end else if (scl_fall && bcnt == 4'd8) begin
            bcnt <= '0;
            case (st)
              S_DEV: begin
                if (sreg[7:1] == {DEV_ID, strap}) begin
                  rw      <= sreg[0];
                  sda_low <= 1'b1;
                  st      <= S_DACK;
                end else begin
                  st <= S_IDLE;
                end
              end
              S_AH: begin
                hi      <= sreg[HI_W-1:0];
                sda_low <= 1'b1;
                st      <= S_AHACK;
              end
              default: begin
                waddr   <= {hi, sreg};
                sda_low <= 1'b1;
                st      <= S_ALACK;
              end
            endcase
          end
        end
        S_DACK: if (scl_fall) begin
          bcnt <= '0;
          if (rw) begin
            txsr    <= mem_data;
            sda_low <= ~mem_data[7];
            st      <= S_TX;
          end else begin
            sda_low <= 1'b0;
            st      <= S_AH;
          end
        end
        S_AHACK: if (scl_fall) begin
          sda_low <= 1'b0;
          st      <= S_AL;
        end
        S_ALACK: if (scl_fall) begin
          sda_low <= 1'b0;
          st      <= S_IDLE;
        end
        S_TX: if (scl_fall) begin
          if (bcnt == 4'd7) begin
            sda_low <= 1'b0;
            waddr   <= waddr + 1'b1;
            st      <= S_TACK;
          end else begin
            txsr    <= {txsr[6:0], 1'b0};
            sda_low <= ~txsr[6];
          end
          bcnt <= bcnt + 4'd1;
        end
        S_TACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            bcnt <= '0;
            if (mack) begin
              txsr    <= mem_data;
              sda_low <= ~mem_data[7];
              st      <= S_TX;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module i2c_eeprom_rd_chk #(
  parameter int         AW     = 14,
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          start_c,
  input logic          stop_c,
  input logic          sda_low,
  input logic [3:0]    st,
  input logic [7:0]    sreg,
  input logic [2:0]    strap,
  input logic [AW-1:0] waddr
);
  // R10
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low) |-> !scl_s);

  // R9
  start_stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c || stop_c) |=> !sda_low);

  // R2 R3
  dev_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_low) && $past(st) == 4'd1) |-> $past(sreg[7:1]) == {DEV_ID, $past(strap)});

  // R7 R8
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(waddr) && $past(st) == 4'd7) |-> waddr == $past(waddr) + 1'b1);

  // R3 R4
  addr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(waddr) |-> ($past(st) == 4'd7 || $past(st) == 4'd5));
endmodule

bind i2c_eeprom_rd_slave i2c_eeprom_rd_chk #(.AW(AW), .DEV_ID(DEV_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_c(start_c), .stop_c(stop_c),
  .sda_low(sda_low), .st(st), .sreg(sreg), .strap(strap), .waddr(waddr)
);

// File: tb/i2c_eeprom_rd_slave_bench.sv
module i2c_eeprom_rd_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 12;
  localparam logic [2:0] STRAP = 3'b101;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_low;
  logic [13:0] mem_addr;
  logic [7:0]  mem_data;
  logic        sda_bus;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [13:0] cur = '0;

  assign sda_bus = sda_m & ~sda_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input logic [13:0] a);
    return a[7:0] ^ {a[13:8], 2'b01} ^ 8'hC3;
  endfunction

  always_ff @(posedge clk) mem_data <= pat(mem_addr);

  i2c_eeprom_rd_slave u_i2c_eeprom_rd_slave (
    .clk(clk), .rst_n(rst_n), .strap(STRAP), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_low(sda_low), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b1; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(Q);
      scl_m = 1'b1; hold(Q);
      scl_m = 1'b0; hold(Q);
    end
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(1);
    ack = ~sda_bus;
    hold(Q-2);
    ack = ack & ~sda_bus;
    hold(1);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] b, output bit stable);
    bit v1, v2;
    stable = 1'b1;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(Q);
      scl_m = 1'b1; hold(1);
      v1 = sda_bus;
      hold(Q-2);
      v2 = sda_bus;
      if (v1 != v2) stable = 1'b0;
      b[i] = v2;
      hold(1);
      scl_m = 1'b0;
    end
    hold(Q);
    sda_m = give_ack ? 1'b0 : 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    scl_m = 1'b0; hold(Q);
    sda_m = 1'b1;
  endtask

  task automatic read_n(input int n, input string req);
    logic [7:0] d;
    bit st;
    for (int i = 0; i < n; i++) begin
      read_byte(i != n-1, d, st);
      chk(d == pat(cur), req, {24'h0, d}, {24'h0, pat(cur)});
      chk(st, "R10", {31'h0, st}, 32'h1);
      cur = cur + 1'b1;
    end
    chk(!sda_low, "R9", {31'h0, sda_low}, 32'h0);
  endtask

  task automatic t_reset();
    chk(!sda_low, "R1", {31'h0, sda_low}, 32'h0);
    chk(mem_addr == 14'h0, "R1", {18'h0, mem_addr}, 32'h0);
  endtask

  task automatic t_random(input logic [7:0] hi, input logic [7:0] lo, input int n, input string req);
    bit a;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, a);
    chk(a, "R2", {31'h0, a}, 32'h1);
    send_byte(hi, a);
    chk(a, "R4", {31'h0, a}, 32'h1);
    send_byte(lo, a);
    chk(a, "R4", {31'h0, a}, 32'h1);
    cur = {hi[5:0], lo};
    chk(mem_addr == cur, "R4", {18'h0, mem_addr}, {18'h0, cur});
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, a);
    chk(a, "R2", {31'h0, a}, 32'h1);
    read_n(n, req);
    bus_stop();
  endtask

  task automatic t_current(input int n, input string req);
    bit a;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, a);
    chk(a, "R6", {31'h0, a}, 32'h1);
    read_n(n, req);
    bus_stop();
    chk(mem_addr == cur, "R6", {18'h0, mem_addr}, {18'h0, cur});
  endtask

  task automatic t_mismatch();
    bit a;
    bus_start();
    send_byte({4'b1010, 3'b010, 1'b0}, a);
    chk(!a, "R3", {31'h0, a}, 32'h0);
    send_byte(8'h00, a);
    chk(!a, "R3", {31'h0, a}, 32'h0);
    send_byte(8'h00, a);
    chk(!a, "R3", {31'h0, a}, 32'h0);
    bus_stop();
    bus_start();
    send_byte({4'b1011, STRAP, 1'b1}, a);
    chk(!a, "R3", {31'h0, a}, 32'h0);
    bus_stop();
    chk(mem_addr == cur, "R3", {18'h0, mem_addr}, {18'h0, cur});
    t_current(1, "R3");
  endtask

  task automatic t_nack_idle();
    bit a;
    logic [7:0] d;
    bit st;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, a);
    chk(a, "R6", {31'h0, a}, 32'h1);
    read_byte(1'b0, d, st);
    chk(d == pat(cur), "R9", {24'h0, d}, {24'h0, pat(cur)});
    cur = cur + 1'b1;
    chk(!sda_low, "R9", {31'h0, sda_low}, 32'h0);
    send_byte(8'hFF, a);
    chk(!a, "R9", {31'h0, a}, 32'h0);
    chk(!sda_low, "R9", {31'h0, sda_low}, 32'h0);
    bus_stop();
  endtask

  initial begin
    hold(5);
    rst_n = 1'b1;
    hold(5);
    t_reset();
    t_random(8'h12, 8'h34, 1, "R5");
    t_current(1, "R6");
    t_random(8'hFF, 8'h10, 1, "R4");
    t_random(8'h3F, 8'hFE, 4, "R8");
    t_current(3, "R7");
    t_random(8'h05, 8'hA0, 3, "R7");
    t_mismatch();
    t_nack_idle();
    t_current(2, "R6");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule